// File: doc/BRIEF.md
# Dual-Mode Converter Bus Interface

This block is the digital control and bus front end of an 8-bit converter. It watches chip-select, write and read strobes from a host bus, starts the conversion core, captures the core's result and overflow flag in an output register, and signals completion. Completion is shown on an active-low interrupt line and on an open-drain ready line. The physical pads are outside the block. The tri-state data bus appears here as a data vector plus an enable, and the open-drain ready line as an enable plus a constant-low value.

A mode input picks one of two start protocols.

- **Read-triggered mode (mode low):** a falling read edge with chip-select low starts the conversion. The bus stays disabled until the core reports completion. Ready is pulled low from the chip-select fall until the result is captured.
- **Write-then-read mode (mode high):** a falling write edge with chip-select low starts the conversion. The result is captured a parameterised number of clocks after write rises. A read that falls before that timeout captures the result at once.

The mode input should carry a weak pull-down at the pad, so that an open pin selects read-triggered mode. All strobes and the mode input are asynchronous and pass through two-flop synchronisers. Edges are detected on the system clock.

States:

| State | Meaning |
|---|---|
| `S_IDLE` | Waiting for a start |
| `S_WR_HELD` | Write is low after a write start |
| `S_WR_WAIT` | Timeout running |
| `S_RD_CONV` | Read-mode conversion in progress |

Transitions:

- IDLE→WR_HELD: write fall with chip-select low, mode high.
- IDLE→RD_CONV: read fall with chip-select low, mode low.
- WR_HELD→WR_WAIT: write rise.
- WR_WAIT→IDLE: read fall with chip-select low (early capture), or timeout expiry.
- RD_CONV→IDLE: core done.

Top module: `cvt_bus_if`

## Requirements
- R1: While chip-select is high, write and read falls start nothing: no start pulse, no interrupt change and no bus enable.
- R2: In write-then-read mode, a write fall with chip-select low in S_IDLE gives exactly one one-cycle `core_start` pulse.
- R3: Without an early read, `int_n` goes low on rising clock edge number TIMEOUT_CYC+3, counting the first edge that samples write high as edge 1. The result register then holds `core_data`.
- R4: A read fall with chip-select low during the timeout captures `core_data` at once and drives `int_n` low before the timeout would have expired.
- R5: In read-triggered mode, a read fall with chip-select low starts a conversion. `db_oe` stays low until `core_done` is seen, and then rises in the same cycle the result is captured.
- R6: In read-triggered mode, `rdy_oe` goes to 1 after chip-select falls and returns to 0 when the result is captured. `rdy_val` is always 0.
- R7: After a capture, a rise of read or of chip-select returns `int_n` to 1.
- R8: `db_oe` is 1 only while chip-select and read are both low and no conversion is pending. `db_out` always shows the result register.
- R9: `ofl_n` is the inverse of the captured overflow flag and is always driven, whatever the state of chip-select and read.
- R10: After reset: `int_n`=1, `db_oe`=0, `rdy_oe`=0, `ofl_n`=1, `db_out`=0 and no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_rd | input | 1 | 1 = write-then-read mode, 0 = read-triggered mode |
| cs_n | input | 1 | Chip-select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| core_done | input | 1 | One-cycle completion pulse from the core |
| core_data | input | DATA_W | Conversion result from the core |
| core_over | input | 1 | Core overflow flag (input above top of range) |
| core_start | output | 1 | One-cycle start request to the core |
| db_out | output | DATA_W | Result register toward the data pads |
| db_oe | output | 1 | Data pad enable |
| int_n | output | 1 | Active-low completion interrupt |
| rdy_oe | output | 1 | Ready pad enable (pulls low when 1) |
| rdy_val | output | 1 | Ready pad value, constant 0 |
| ofl_n | output | 1 | Active-low overflow, always driven |

## Verification
The following are checked on every cycle by assertions:

- a start pulse needs chip-select low and lasts one cycle;
- every capture is followed by a low interrupt and a released ready line;
- a rise of read or chip-select, with no new capture, returns the interrupt high;
- the timeout counter stays in range;
- the bus is never enabled while a read-mode conversion is pending.

Only the bench's scenarios can show the rest. That covers the exact clock count from write rise to interrupt, the choice between early-read capture and timeout capture, and the value carried into the result register. It also covers strobes ignored with chip-select high, and the interplay of mode, ready and bus enable across whole transactions.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_WR_HELD = 2'd1,
        S_WR_WAIT = 2'd2,
        S_RD_CONV = 2'd3
    } cvt_state_e;

    // bit positions inside the synchronised strobe vector
    localparam int unsigned STB_CS = 0;
    localparam int unsigned STB_WR = 1;
    localparam int unsigned STB_RD = 2;
    localparam int unsigned STB_W  = 3;

endpackage

// File: rtl/cvt_sync.sv
module cvt_sync #(
    parameter int unsigned   W       = 1,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [STAGES-1:0][W-1:0] pipe;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[g] <= RST_VAL;
                end else if (g == 0) begin
                    pipe[g] <= async_in;
                end else begin
                    pipe[g] <= pipe[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_out = pipe[STAGES-1];

endmodule

// File: rtl/cvt_timer.sv
module cvt_timer #(
    parameter int unsigned CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: the count never passes the expiry value
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(CYCLES - 1));

endmodule

// File: rtl/cvt_result.sv
module cvt_result #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] data_in,
    input  logic              over_in,
    output logic [DATA_W-1:0] data_q,
    output logic              ofl_n
);

    logic over_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            over_q <= 1'b0;
        end else if (cap_en) begin
            data_q <= data_in;
            over_q <= over_in;
        end
    end

    assign ofl_n = ~over_q;

    // R9: overflow output only moves on a capture
    a_r9_ofl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(ofl_n));

endmodule

// File: rtl/cvt_bus_if.sv
module cvt_bus_if
    import cvt_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned TIMEOUT_CYC = 40,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr_rd,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              core_done,
    input  logic [DATA_W-1:0] core_data,
    input  logic              core_over,
    output logic              core_start,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    output logic              int_n,
    output logic              rdy_oe,
    output logic              rdy_val,
    output logic              ofl_n
);

    logic [STB_W-1:0] stb_lvl, stb_dly;
    logic             mode_hi;
    logic             cs_act, rd_act;
    logic             cs_rise, cs_fall, wr_rise, wr_fall, rd_rise, rd_fall;
    logic             tmo, timer_run, cap_en;
    cvt_state_e       state, state_d;

    // strobe synchronisers (inactive high at reset) and mode synchroniser
    cvt_sync #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL({STB_W{1'b1}})) u_sync_stb (
        .clk(clk), .rst_n(rst_n),
        .async_in({rd_n, wr_n, cs_n}),
        .sync_out(stb_lvl)
    );

    cvt_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mode (
        .clk(clk), .rst_n(rst_n),
        .async_in(mode_wr_rd),
        .sync_out(mode_hi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_dly <= {STB_W{1'b1}};
        else        stb_dly <= stb_lvl;
    end

    assign cs_act  = ~stb_lvl[STB_CS];
    assign rd_act  = ~stb_lvl[STB_RD];
    assign cs_rise =  stb_lvl[STB_CS] & ~stb_dly[STB_CS];
    assign cs_fall = ~stb_lvl[STB_CS] &  stb_dly[STB_CS];
    assign wr_rise =  stb_lvl[STB_WR] & ~stb_dly[STB_WR];
    assign wr_fall = ~stb_lvl[STB_WR] &  stb_dly[STB_WR];
    assign rd_rise =  stb_lvl[STB_RD] & ~stb_dly[STB_RD];
    assign rd_fall = ~stb_lvl[STB_RD] &  stb_dly[STB_RD];

    assign timer_run = (state == S_WR_WAIT);

    cvt_timer #(.CYCLES(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(timer_run), .expired(tmo)
    );

    cvt_result #(.DATA_W(DATA_W)) u_result (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
        .data_in(core_data), .over_in(core_over),
        .data_q(db_out), .ofl_n(ofl_n)
    );

    // next-state and strobe decode
    always_comb begin
        state_d    = state;
        cap_en     = 1'b0;
        core_start = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cs_act && mode_hi && wr_fall) begin
                    core_start = 1'b1;
                    state_d    = S_WR_HELD;
                end else if (cs_act && !mode_hi && rd_fall) begin
                    core_start = 1'b1;
                    state_d    = S_RD_CONV;
                end
            end
            S_WR_HELD: begin
                if (wr_rise) state_d = S_WR_WAIT;
            end
            S_WR_WAIT: begin
                if ((cs_act && rd_fall) || tmo) begin
                    cap_en  = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_RD_CONV: begin
                if (core_done) begin
                    cap_en  = 1'b1;
                    state_d = S_IDLE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_n  <= 1'b1;
            rdy_oe <= 1'b0;
            db_oe  <= 1'b0;
        end else begin
            if (cap_en)                  int_n <= 1'b0;
            else if (rd_rise || cs_rise) int_n <= 1'b1;

            if (cap_en)                  rdy_oe <= 1'b0;
            else if (cs_fall && !mode_hi) rdy_oe <= 1'b1;

            db_oe <= cs_act && rd_act &&
                     (state_d != S_RD_CONV) && (state_d != S_WR_WAIT);
        end
    end

    assign rdy_val = 1'b0;

    // R1: a start needs chip-select asserted
    a_r1_start_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> cs_act);
    // R2: start request is a single-cycle pulse
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);
    // R4: every capture drops the interrupt
    a_r4_int_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> !int_n);
    // R5: bus stays off while a read-mode conversion is pending
    a_r5_no_bus_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_CONV) |-> !db_oe);
    // R6: ready released once the result is captured
    a_r6_rdy_release: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> !rdy_oe);
    // R7: rise of read or chip-select clears the interrupt
    a_r7_int_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_rise || cs_rise) && !cap_en) |=> int_n);
    // R6: ready pad value is never driven high
    a_r6_rdy_low: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_val == 1'b0);

endmodule

// File: tb/cvt_bus_if_tb.sv
module cvt_bus_if_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int TMO        = 12;
    localparam int CORE_LAT   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr_rd = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic core_done = 1'b0;
    logic [DATA_W-1:0] core_data = '0;
    logic core_over = 1'b0;
    logic core_start;
    logic [DATA_W-1:0] db_out;
    logic db_oe, int_n, rdy_oe, rdy_val, ofl_n;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cvt_bus_if #(.DATA_W(DATA_W), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr_rd(mode_wr_rd),
        .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .core_done(core_done), .core_data(core_data), .core_over(core_over),
        .core_start(core_start), .db_out(db_out), .db_oe(db_oe),
        .int_n(int_n), .rdy_oe(rdy_oe), .rdy_val(rdy_val), .ofl_n(ofl_n)
    );

    // conversion core model: done pulse CORE_LAT cycles after a start
    int lat_cnt = 0;
    always @(posedge clk) begin
        core_done <= 1'b0;
        if (core_start) begin
            starts  <= starts + 1;
            lat_cnt <= CORE_LAT;
        end else if (lat_cnt > 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) core_done <= 1'b1;
        end
    end

    function automatic int exp_tmo_edges();
        return TMO + 3;
    endfunction

    function automatic logic exp_ofl(input logic over);
        return ~over;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        mode_wr_rd = m;
        tick(4);
    endtask

    // write-then-read transaction
    task automatic conv_wr(input logic [DATA_W-1:0] d, input logic ov, input bit early);
        int s0, n;
        core_data = d; core_over = ov;
        s0 = starts;
        cs_n = 1'b0; tick(1);
        wr_n = 1'b0; tick(5);
        check(starts == s0 + 1, "R2 one start", starts - s0, 1);
        wr_n = 1'b1;
        if (early) begin
            tick(3);
            rd_n = 1'b0;
            tick(4);
            check(int_n == 1'b0, "R4 early int", int_n, 0);
            check(db_oe == 1'b1, "R4 early oe", db_oe, 1);
            check(db_out == d, "R4 early data", db_out, d);
        end else begin
            n = 0;
            while (int_n == 1'b1 && n < 4 * TMO) begin
                tick(1);
                n++;
            end
            check(n == exp_tmo_edges(), "R3 timeout edges", n, exp_tmo_edges());
            check(db_out == d, "R3 data", db_out, d);
            check(db_oe == 1'b0, "R8 no oe without read", db_oe, 0);
            rd_n = 1'b0;
            tick(4);
            check(db_oe == 1'b1, "R8 oe on read", db_oe, 1);
        end
        check(ofl_n == exp_ofl(ov), "R9 ofl", ofl_n, exp_ofl(ov));
        rd_n = 1'b1;
        tick(4);
        check(int_n == 1'b1, "R7 read rise clears int", int_n, 1);
        check(db_oe == 1'b0, "R8 oe off", db_oe, 0);
        cs_n = 1'b1;
        tick(4);
        check(ofl_n == exp_ofl(ov), "R9 ofl driven cs high", ofl_n, exp_ofl(ov));
    endtask

    // read-triggered transaction, interrupt cleared by chip-select rise
    task automatic conv_rd(input logic [DATA_W-1:0] d, input logic ov);
        int n;
        bit oe_seen;
        core_data = d; core_over = ov;
        cs_n = 1'b0; tick(4);
        check(rdy_oe == 1'b1, "R6 ready pulled low", rdy_oe, 1);
        rd_n = 1'b0;
        n = 0; oe_seen = 1'b0;
        while (int_n == 1'b1 && n < 60) begin
            tick(1);
            if (int_n == 1'b1 && db_oe == 1'b1) oe_seen = 1'b1;
            n++;
        end
        check(!oe_seen, "R5 no oe before done", oe_seen, 0);
        check(int_n == 1'b0, "R5 conversion completes", int_n, 0);
        check(db_oe == 1'b1, "R5 oe after done", db_oe, 1);
        check(db_out == d, "R5 data", db_out, d);
        check(rdy_oe == 1'b0, "R6 ready released", rdy_oe, 0);
        check(ofl_n == exp_ofl(ov), "R9 ofl", ofl_n, exp_ofl(ov));
        cs_n = 1'b1;
        tick(4);
        check(int_n == 1'b1, "R7 cs rise clears int", int_n, 1);
        check(db_oe == 1'b0, "R8 oe off with cs high", db_oe, 0);
        rd_n = 1'b1;
        tick(4);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0;
        logic [DATA_W-1:0] prev;
        void'($urandom(32'd2718));
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R10 reset state
        check(int_n == 1'b1, "R10 int", int_n, 1);
        check(db_oe == 1'b0, "R10 oe", db_oe, 0);
        check(rdy_oe == 1'b0, "R10 rdy", rdy_oe, 0);
        check(ofl_n == 1'b1, "R10 ofl", ofl_n, 1);
        check(db_out == '0, "R10 data", db_out, 0);
        check(starts == 0, "R10 no start", starts, 0);
        check(rdy_val == 1'b0, "R6 rdy_val", rdy_val, 0);

        // directed corners
        set_mode(1'b1);
        conv_wr(8'hA5, 1'b1, 1'b0);
        conv_wr(8'h3C, 1'b0, 1'b1);
        set_mode(1'b0);
        conv_rd(8'hFF, 1'b1);
        conv_rd(8'h00, 1'b0);

        // R1: strobes with chip-select high are ignored
        prev = db_out;
        s0 = starts;
        set_mode(1'b1);
        wr_n = 1'b0; tick(5); wr_n = 1'b1; tick(TMO + 8);
        check(starts == s0, "R1 wr ignored", starts - s0, 0);
        check(int_n == 1'b1, "R1 int unchanged", int_n, 1);
        set_mode(1'b0);
        rd_n = 1'b0; tick(CORE_LAT + 8);
        check(starts == s0, "R1 rd ignored", starts - s0, 0);
        check(db_oe == 1'b0, "R1 no oe", db_oe, 0);
        check(rdy_oe == 1'b0, "R1 ready idle", rdy_oe, 0);
        rd_n = 1'b1; tick(4);
        check(db_out == prev, "R1 latch unchanged", db_out, prev);

        // constrained random transactions
        for (int i = 0; i < 24; i++) begin
            logic [DATA_W-1:0] d;
            logic ov, m;
            bit early;
            d = DATA_W'($urandom);
            ov = 1'($urandom);
            m = 1'($urandom);
            early = 1'($urandom);
            set_mode(m);
            if (m) conv_wr(d, ov, early);
            else   conv_rd(d, ov);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule